// File: doc/BRIEF.md
# FP8 Two-Way Dot-Product Accumulator

This block takes two 16-bit operand words and one half-precision accumulator. Each operand word carries two 8-bit floating-point values. The block widens the four 8-bit values exactly and forms the two cross products. It adds the products together, divides the sum by a power of two chosen by an unsigned scale input, and adds the result to the accumulator. The final value is rounded once to half precision. This is one accumulate step of a tile of outer products, in which every tile element is updated from one row pair and one column pair.

Each operand word has its own format select, so row and column values can use different 8-bit encodings. Encoding 0 is E4M3: bias 7, no infinities, and the all-ones code in exponent and mantissa is NaN. Encoding 1 is E5M2: bias 15, with IEEE-style infinities and NaNs. The datapath is a two-stage pipeline. It accepts one operation per cycle and marks each result with a valid flag.

Top module: `fp8_dot2_acc`

## Requirements
- R1: In each operand word, element 0 sits in bits [7:0] and element 1 in bits [15:8]. Element 0 of one word pairs with element 0 of the other, and element 1 with element 1.
- R2: With format 0 (E4M3), bits are sign[7], exp[6:3] and man[2:0], with bias 7. Exponent 0 encodes exact subnormals. Code 0x7E is 448 and code 0x7F is NaN.
- R3: With format 1 (E5M2), bits are sign[7], exp[6:2] and man[1:0], with bias 15. Exponent 31 with man 0 is infinity, and exponent 31 with any other man is NaN.
- R4: The two format selects act independently. `fmt_a_i` decodes `a_i` and `fmt_b_i` decodes `b_i`.
- R5: res = acc + 2^(-scale)·(a0·b0 + a1·b1), computed exactly and rounded once to half precision, to nearest with ties to even.
- R6: Results below the normal half-precision range round to subnormals or to zero. Nothing is flushed before the final rounding.
- R7: A finite result whose magnitude rounds past 65504 becomes 0x7C00, or 0xFC00 when negative.
- R8: Any NaN input, an infinity times zero, or infinities of opposite sign in the sum all yield 0x7E00.
- R9: If no NaN case applies, an infinite product or accumulator gives an infinity of the same sign.
- R10: An exact zero result is +0 (0x0000). The only exception is when the accumulator and both products are all negative zeros, which gives 0x8000.
- R11: `valid_o` and `res_o` follow `valid_i` and its operands by exactly two clock cycles. A new operation may enter on every cycle.
- R12: While `rst_ni` is low, `valid_o` and `res_o` are 0. After a cycle in which `valid_o` is low, `res_o` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operand set is valid this cycle |
| a_i | input | 16 | Row operand pair, element 0 in low byte |
| b_i | input | 16 | Column operand pair, element 0 in low byte |
| acc_i | input | 16 | Half-precision accumulator |
| fmt_a_i | input | 1 | Encoding of a_i: 0 = E4M3, 1 = E5M2 |
| fmt_b_i | input | 1 | Encoding of b_i: 0 = E4M3, 1 = E5M2 |
| scale_i | input | SCALE_W (4) | Downscale exponent, unsigned |
| valid_o | output | 1 | Result is valid |
| res_o | output | 16 | Rounded half-precision result |

## Verification
The bench uses the default SCALE_W of 4. With that width the full scale range 0 to 15 is reachable, and so is the deepest alignment the fixed-point sum must hold. Products of E5M2 subnormals can be pushed down to the smallest half-precision subnormal or below it. Scale values of 5 with a unit accumulator place the scaled dot product exactly at half an ulp, which tests ties-to-even and sticky-bit rounding. Format pairs that mix the two encodings decode the same code, 0x7E, both as a finite value and as NaN.

// File: rtl/fp8dp_pkg.sv
package fp8dp_pkg;
  typedef enum logic {FMT_E4M3 = 1'b0, FMT_E5M2 = 1'b1} f8_fmt_e;

  // value = sig * 2^exp
  typedef struct packed {
    logic               sgn;
    logic               nan;
    logic               inf;
    logic               zero;
    logic [10:0]        sig;
    logic signed [7:0]  exp;
  } unp_t;

  localparam int PROD_EXP_MIN = -32;  // smallest exponent of a product LSB
  localparam int ACC_EXP_MIN  = -24;  // smallest half-precision subnormal
endpackage

// File: rtl/fp8_unpack.sv
module fp8_unpack
  import fp8dp_pkg::*;
(
  input  logic [7:0] code_i,
  input  logic       fmt_i,
  output unp_t       val_o
);
  logic [4:0] ef;
  logic [2:0] man;

  always_comb begin
    val_o     = '0;
    val_o.sgn = code_i[7];
    if (f8_fmt_e'(fmt_i) == FMT_E4M3) begin
      ef  = {1'b0, code_i[6:3]};
      man = code_i[2:0];
      val_o.nan = (ef == 5'd15) && (man == 3'd7);
      val_o.sig = {7'd0, (ef != 5'd0), man};
      val_o.exp = signed'({3'd0, (ef == 5'd0) ? 5'd1 : ef}) - 8'sd10;
    end else begin
      ef  = code_i[6:2];
      man = {1'b0, code_i[1:0]};
      val_o.nan = (ef == 5'd31) && (man != 3'd0);
      val_o.inf = (ef == 5'd31) && (man == 3'd0);
      val_o.sig = {8'd0, (ef != 5'd0), man[1:0]};
      val_o.exp = signed'({3'd0, (ef == 5'd0) ? 5'd1 : ef}) - 8'sd17;
    end
    val_o.zero = (ef == 5'd0) && (man == 3'd0);
  end
endmodule

// File: rtl/fp16_unpack.sv
module fp16_unpack
  import fp8dp_pkg::*;
(
  input  logic [15:0] code_i,
  output unp_t        val_o
);
  logic [4:0] ef;
  logic [9:0] man;

  always_comb begin
    ef         = code_i[14:10];
    man        = code_i[9:0];
    val_o.sgn  = code_i[15];
    val_o.nan  = (ef == 5'd31) && (man != 10'd0);
    val_o.inf  = (ef == 5'd31) && (man == 10'd0);
    val_o.zero = (ef == 5'd0) && (man == 10'd0);
    val_o.sig  = {(ef != 5'd0), man};
    val_o.exp  = signed'({3'd0, (ef == 5'd0) ? 5'd1 : ef}) - 8'sd25;
  end
endmodule

// File: rtl/fp8dp_lane.sv
module fp8dp_lane
  import fp8dp_pkg::*;
#(
  parameter int W       = 83,
  parameter int FRAC    = 47,
  parameter int SCALE_W = 4
) (
  input  unp_t                a_i,
  input  unp_t                b_i,
  input  logic [SCALE_W-1:0]  scale_i,
  output logic signed [W-1:0] term_o,
  output logic                nan_o,
  output logic                pinf_o,
  output logic                ninf_o,
  output logic                zero_o,
  output logic                sgn_o
);
  logic [7:0]   prod;
  logic [W-1:0] mag;
  int           sh;
  logic         inf;

  always_comb begin
    sgn_o  = a_i.sgn ^ b_i.sgn;
    prod   = 8'(a_i.sig[3:0]) * 8'(b_i.sig[3:0]);
    sh     = int'(a_i.exp) + int'(b_i.exp) - int'(scale_i) + FRAC;
    mag    = W'(prod) << sh;
    term_o = sgn_o ? -signed'(mag) : signed'(mag);
    inf    = a_i.inf | b_i.inf;
    nan_o  = a_i.nan | b_i.nan | (a_i.inf & b_i.zero) | (a_i.zero & b_i.inf);
    pinf_o = inf & ~sgn_o;
    ninf_o = inf & sgn_o;
    zero_o = a_i.zero | b_i.zero;
  end
endmodule

// File: rtl/fp8dp_round.sv
module fp8dp_round #(
  parameter int W    = 83,
  parameter int FRAC = 47
) (
  input  logic signed [W-1:0] sum_i,
  output logic [15:0]         res_o
);
  localparam int NORM_MIN = FRAC - 14;  // bit index of 2^-14
  localparam int SUB_LSB  = FRAC - 24;  // bit index of 2^-24

  logic         sgn;
  logic [W-1:0] mag, kept_w, mask;
  logic [10:0]  kept;
  logic         g, st;
  logic [16:0]  bits;
  int           p, lsb;

  always_comb begin
    sgn = sum_i[W-1];
    mag = sgn ? W'(-sum_i) : W'(sum_i);
    p   = 0;
    for (int i = 0; i < W; i++) if (mag[i]) p = i;
    lsb    = (p >= NORM_MIN) ? p - 10 : SUB_LSB;
    kept_w = mag >> lsb;
    kept   = kept_w[10:0];
    g      = mag[lsb-1];
    mask   = (W'(1) << (lsb - 1)) - W'(1);
    st     = |(mag & mask);
    // hidden bit in kept[10] carries into the exponent field
    bits   = 17'(kept) + 17'(g & (st | kept[0]));
    if (p >= NORM_MIN) bits = bits + 17'((p - FRAC + 14) << 10);
    res_o = (bits >= 17'h07C00) ? {sgn, 15'h7C00} : {sgn, bits[14:0]};
  end
endmodule

// File: rtl/fp8_dot2_acc.sv
module fp8_dot2_acc
  import fp8dp_pkg::*;
#(
  parameter int SCALE_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [15:0]        a_i,
  input  logic [15:0]        b_i,
  input  logic [15:0]        acc_i,
  input  logic               fmt_a_i,
  input  logic               fmt_b_i,
  input  logic [SCALE_W-1:0] scale_i,
  output logic               valid_o,
  output logic [15:0]        res_o
);
  localparam int SCALE_MAX = (1 << SCALE_W) - 1;
  localparam int FRAC      = -PROD_EXP_MIN + SCALE_MAX;
  localparam int W         = FRAC + 36;
  localparam int LANES     = 2;

  unp_t ua [LANES];
  unp_t ub [LANES];
  unp_t uc;
  logic signed [W-1:0] term [LANES];
  logic [LANES-1:0] l_nan, l_pinf, l_ninf, l_zero, l_sgn;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    fp8_unpack u_ua (.code_i(a_i[8*g +: 8]), .fmt_i(fmt_a_i), .val_o(ua[g]));
    fp8_unpack u_ub (.code_i(b_i[8*g +: 8]), .fmt_i(fmt_b_i), .val_o(ub[g]));
    fp8dp_lane #(.W(W), .FRAC(FRAC), .SCALE_W(SCALE_W)) u_lane (
      .a_i(ua[g]), .b_i(ub[g]), .scale_i(scale_i),
      .term_o(term[g]), .nan_o(l_nan[g]), .pinf_o(l_pinf[g]),
      .ninf_o(l_ninf[g]), .zero_o(l_zero[g]), .sgn_o(l_sgn[g])
    );
  end

  fp16_unpack u_uc (.code_i(acc_i), .val_o(uc));

  logic [W-1:0]        acc_mag;
  logic signed [W-1:0] sum_d;
  logic                pinf_d, ninf_d, nan_d, negz_d;

  always_comb begin
    acc_mag = W'(uc.sig) << (int'(uc.exp) + FRAC);
    sum_d   = uc.sgn ? -signed'(acc_mag) : signed'(acc_mag);
    for (int i = 0; i < LANES; i++) sum_d = sum_d + term[i];
    pinf_d = (|l_pinf) | (uc.inf & ~uc.sgn);
    ninf_d = (|l_ninf) | (uc.inf & uc.sgn);
    nan_d  = (|l_nan) | uc.nan | (pinf_d & ninf_d);
    negz_d = (&l_zero) & (&l_sgn) & uc.zero & uc.sgn;
  end

  // stage 1: aligned exact sum and special-case flags
  logic                s1_valid, s1_nan, s1_pinf, s1_ninf, s1_negz;
  logic signed [W-1:0] s1_sum;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid <= 1'b0;
      s1_sum   <= '0;
      s1_nan   <= 1'b0;
      s1_pinf  <= 1'b0;
      s1_ninf  <= 1'b0;
      s1_negz  <= 1'b0;
    end else begin
      s1_valid <= valid_i;
      if (valid_i) begin
        s1_sum  <= sum_d;
        s1_nan  <= nan_d;
        s1_pinf <= pinf_d;
        s1_ninf <= ninf_d;
        s1_negz <= negz_d;
      end
    end
  end

  // stage 2: normalise, round, pack
  logic [15:0] rnd;
  logic [15:0] res_d;

  fp8dp_round #(.W(W), .FRAC(FRAC)) u_round (.sum_i(s1_sum), .res_o(rnd));

  always_comb begin
    if (s1_nan)       res_d = 16'h7E00;
    else if (s1_pinf) res_d = 16'h7C00;
    else if (s1_ninf) res_d = 16'hFC00;
    else if (s1_negz) res_d = 16'h8000;
    else              res_d = rnd;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res_o   <= '0;
    end else begin
      valid_o <= s1_valid;
      if (s1_valid) res_o <= res_d;
    end
  end
endmodule

// File: rtl/fp8_dot2_acc_chk.sv
module fp8_dot2_acc_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic        valid_o,
  input logic [15:0] res_o
);
  p_latency_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ##2 valid_o);

  p_bubble_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> ##2 !valid_o);

  p_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> ##2 $stable(res_o));

  p_reset_r12: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && res_o == 16'h0000));

  p_nan_canon_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && res_o[14:10] == 5'h1F && res_o[9:0] != 10'h0) |-> res_o == 16'h7E00);
endmodule

bind fp8_dot2_acc fp8_dot2_acc_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
  .valid_o(valid_o), .res_o(res_o)
);

// File: tb/fp8_dot2_acc_tb.sv
module fp8_dot2_acc_tb;
  localparam int NV = 24;
  // {req[77:70], a[69:54], b[53:38], acc[37:22], fa[21], fb[20], scale[19:16], exp[15:0]}
  localparam logic [77:0] VEC [NV] = '{
    {8'd5,  16'h3838, 16'h3838, 16'h0000, 1'b0, 1'b0, 4'd0,  16'h4000}, // R5 1+1
    {8'd5,  16'h3838, 16'h3838, 16'h3C00, 1'b0, 1'b0, 4'd0,  16'h4200}, // R5 acc add
    {8'd5,  16'h3838, 16'h3838, 16'h3C00, 1'b0, 1'b0, 4'd1,  16'h4000}, // R5 scale 1
    {8'd4,  16'h0040, 16'h003E, 16'h0000, 1'b0, 1'b1, 4'd0,  16'h4200}, // R4 E4M3 x E5M2
    {8'd4,  16'h3C3C, 16'h3838, 16'h4000, 1'b1, 1'b0, 4'd2,  16'h4100}, // R4 E5M2 x E4M3
    {8'd1,  16'h38B8, 16'h3840, 16'h0000, 1'b0, 1'b0, 4'd0,  16'hBC00}, // R1 lane pairing
    {8'd10, 16'h3838, 16'hB838, 16'h0000, 1'b0, 1'b0, 4'd0,  16'h0000}, // R10 cancel +0
    {8'd2,  16'h0001, 16'h0038, 16'h0000, 1'b0, 1'b0, 4'd0,  16'h1800}, // R2 subnormal in
    {8'd6,  16'h0001, 16'h003C, 16'h0000, 1'b1, 1'b1, 4'd8,  16'h0001}, // R6 min subnormal
    {8'd5,  16'h0008, 16'h0038, 16'h3C00, 1'b0, 1'b0, 4'd5,  16'h3C00}, // R5 tie even down
    {8'd5,  16'h0008, 16'h0038, 16'h3C01, 1'b0, 1'b0, 4'd5,  16'h3C02}, // R5 tie even up
    {8'd5,  16'h0108, 16'h3838, 16'h3C00, 1'b0, 1'b0, 4'd5,  16'h3C01}, // R5 sticky
    {8'd7,  16'h007B, 16'h003C, 16'h7BFF, 1'b1, 1'b1, 4'd0,  16'h7C00}, // R7 +overflow
    {8'd8,  16'h007F, 16'h0038, 16'h0000, 1'b0, 1'b0, 4'd0,  16'h7E00}, // R8 E4M3 NaN
    {8'd8,  16'h007C, 16'h0000, 16'h0000, 1'b1, 1'b1, 4'd0,  16'h7E00}, // R8 inf*0
    {8'd9,  16'h007C, 16'h003C, 16'h0000, 1'b1, 1'b1, 4'd0,  16'h7C00}, // R9 +inf
    {8'd8,  16'h007C, 16'h003C, 16'hFC00, 1'b1, 1'b1, 4'd0,  16'h7E00}, // R8 inf-inf
    {8'd10, 16'h8080, 16'h3838, 16'h8000, 1'b0, 1'b0, 4'd0,  16'h8000}, // R10 all -0
    {8'd2,  16'h007E, 16'h0038, 16'h0000, 1'b0, 1'b0, 4'd0,  16'h5F00}, // R2 448
    {8'd3,  16'h007E, 16'h0038, 16'h0000, 1'b1, 1'b0, 4'd0,  16'h7E00}, // R3 0x7E is NaN
    {8'd1,  16'h3800, 16'h4000, 16'h0000, 1'b0, 1'b0, 4'd0,  16'h4000}, // R1 high byte
    {8'd7,  16'h00FB, 16'h003C, 16'hFBFF, 1'b1, 1'b1, 4'd0,  16'hFC00}, // R7 -overflow
    {8'd9,  16'h00FC, 16'h003C, 16'h0000, 1'b1, 1'b1, 4'd0,  16'hFC00}, // R9 -inf
    {8'd6,  16'h0001, 16'h003C, 16'h0000, 1'b1, 1'b1, 4'd15, 16'h0000}  // R6 underflow
  };

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        valid_i;
  logic [15:0] a_i, b_i, acc_i;
  logic        fmt_a_i, fmt_b_i;
  logic [3:0]  scale_i;
  logic        valid_o;
  logic [15:0] res_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk_i = ~clk_i;

  fp8_dot2_acc #(.SCALE_W(4)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .a_i(a_i), .b_i(b_i),
    .acc_i(acc_i), .fmt_a_i(fmt_a_i), .fmt_b_i(fmt_b_i), .scale_i(scale_i),
    .valid_o(valid_o), .res_o(res_o)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic drive(input logic [77:0] v);
    valid_i = 1'b1;
    a_i     = v[69:54];
    b_i     = v[53:38];
    acc_i   = v[37:22];
    fmt_a_i = v[21];
    fmt_b_i = v[20];
    scale_i = v[19:16];
  endtask

  initial begin
    rst_ni  = 1'b1;
    valid_i = 1'b0;
    a_i = '0; b_i = '0; acc_i = '0;
    fmt_a_i = 1'b0; fmt_b_i = 1'b0; scale_i = '0;
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R12 reset valid", {15'd0, valid_o}, 16'd0);
    check("R12 reset res", res_o, 16'h0000);
    rst_ni = 1'b1;

    // table walk, one operation in flight
    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      drive(VEC[i]);
      @(negedge clk_i);
      valid_i = 1'b0;
      @(negedge clk_i);
      check($sformatf("R%0d vec %0d", VEC[i][77:70], i), res_o, VEC[i][15:0]);
      check("R11 valid after 2", {15'd0, valid_o}, 16'd1);
    end

    // back-to-back stream, then a bubble
    @(negedge clk_i);
    for (int c = 0; c < 6; c++) begin
      if (c >= 2 && c < 5) begin
        check("R11 stream res", res_o, VEC[c-2][15:0]);
        check("R11 stream valid", {15'd0, valid_o}, 16'd1);
      end
      if (c == 5) begin
        check("R12 bubble valid low", {15'd0, valid_o}, 16'd0);
        check("R12 hold res", res_o, VEC[2][15:0]);
      end
      if (c < 3) drive(VEC[c]);
      else valid_i = 1'b0;
      @(negedge clk_i);
    end

    // inputs change with valid low: output must not move
    a_i = 16'h007F; b_i = 16'h0038;
    repeat (3) @(negedge clk_i);
    check("R12 idle hold", res_o, VEC[2][15:0]);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule